// File: doc/BRIEF.md
# Nibble-Wide Double-Edge Link Port

This block is a point-to-point link that carries 128-bit quad-words over four data wires. The transmitter takes quad-words from a valid/ready input stream and buffers up to two of them. It splits each quad-word into 32 nibbles and drives them with a forwarded clock. A new nibble appears on every change of that clock, on the rising edge and on the falling edge alike. The forwarded clock is produced by dividing the core clock by a count held on a plain control input. Before it begins a quad-word, the transmitter requires its acknowledge input to be high.

The receiver watches the forwarded clock for changes, collects the nibbles back into quad-words and queues them in a three-entry buffer. That buffer feeds a valid/ready output stream. The receiver drives the acknowledge line, and it keeps the line high only while two or more of its buffers are free. Blocks have a programmable length in quad-words. A block-end line runs beside the data and marks the last quad-word of each block. Each side can enable its own checksum: the transmitter appends a lane-wise byte sum after the block, and the receiver checks that sum.

The whole model runs in the core clock domain. The forwarded clock is an ordinary register, and the receiver finds its changes by comparing it with a delayed copy. The transmit and receive pins are separate ports, so the link can be looped back or joined to another instance.

Back-pressure: the input stream holds `s_data` until `s_ready` is seen high. The output stream holds `m_data` and `m_last` stable while `m_valid` is high and `m_ready` is low.

Top module: `lp_link`

## Requirements
- R1: `s_ready` is high whenever the two-entry transmit buffer has a free entry, including right after reset. A quad-word is accepted on a cycle where `s_valid` and `s_ready` are both high, and quad-words go out in the order they were accepted.
- R2: Each quad-word goes out as 32 nibbles on `lk_dat_o`, least significant nibble first. A nibble is presented together with every change of `lk_clk_o`, and `lk_dat_o` changes only when `lk_clk_o` also changes.
- R3: While a quad-word is being sent, each level of `lk_clk_o` lasts `clk_div` core cycles. A value of 0 is treated as 1.
- R4: `lk_clk_o` is low whenever no quad-word is being sent, and it is low after reset. A quad-word starts only in a cycle where `lk_ack_i` is high. A quad-word that has already started is completed even if `lk_ack_i` falls.
- R5: `lk_ack_o` is high exactly when at least two of the three receive buffers are free, so it is high after reset. The receive buffer is never written while it is full.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold. Quad-words leave in the order in which they were received.
- R7: A block is `blk_len` quad-words long (0 counts as 1). `lk_end_o` is high for the whole of the final quad-word sent for the block. When receive checking is off, the quad-word received with `lk_end_i` high comes out with `m_last` = 1, all others with 0. `rx_blk_done` pulses for one cycle each time a block ends.
- R8: With `tx_ck_en` = 1, the transmitter sends one extra quad-word after the block's data, with `lk_end_o` high. Byte lane k (bits 8k+7..8k) of that quad-word is the sum, modulo 256, of byte lane k of every data quad-word in the block.
- R9: With `rx_ck_en` = 1, the quad-word received with `lk_end_i` high is not delivered. It is compared with the lane-wise byte sum of the data quad-words received since the previous block end. `rx_ck_err` pulses in the same cycle as `rx_blk_done` when the two differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input stream valid |
| s_ready | output | 1 | Input stream ready |
| s_data | input | 128 | Quad-word to send |
| clk_div | input | 8 | Forwarded clock half-period in core cycles |
| blk_len | input | 8 | Quad-words per block |
| tx_ck_en | input | 1 | Append a checksum quad-word after each block |
| lk_clk_o | output | 1 | Forwarded link clock |
| lk_dat_o | output | 4 | Link data nibble |
| lk_end_o | output | 1 | Block-end flag sent with the final quad-word |
| lk_ack_i | input | 1 | Acknowledge from the far receiver |
| lk_clk_i | input | 1 | Incoming link clock |
| lk_dat_i | input | 4 | Incoming data nibble |
| lk_end_i | input | 1 | Incoming block-end flag |
| lk_ack_o | output | 1 | Acknowledge to the far transmitter |
| rx_ck_en | input | 1 | Check the trailing checksum quad-word |
| m_valid | output | 1 | Output stream valid |
| m_ready | input | 1 | Output stream ready |
| m_data | output | 128 | Received quad-word |
| m_last | output | 1 | Quad-word closed its block |
| rx_blk_done | output | 1 | One-cycle pulse when a block ends |
| rx_ck_err | output | 1 | One-cycle pulse on checksum mismatch |

## Verification
The assertions check several properties on every cycle:
- a quad-word never starts without acknowledge;
- the forwarded clock stays low whenever the transmitter is idle;
- nibbles change only together with a clock change;
- the receive buffer is never written when full;
- the output stream holds its data under back-pressure.

Some behaviour can only be shown by the bench's scenarios, because it needs knowledge of the data:
- least-significant-first order on the wire;
- the measured half-period for each divisor;
- the acknowledge level with two buffers occupied and again with one;
- completion of a quad-word whose acknowledge drops part way;
- the block-end flag;
- both checksum paths, with a matching and a mismatching trailing quad-word.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int QW   = 128;
  localparam int NIB  = 4;
  localparam int LANE = 8;
  localparam int NPQ  = QW / NIB;
  localparam int NLN  = QW / LANE;

  typedef logic [QW-1:0] qw_t;

  function automatic qw_t lane_add(input qw_t a, input qw_t b);
    qw_t r;
    for (int i = 0; i < NLN; i++)
      r[i*LANE +: LANE] = a[i*LANE +: LANE] + b[i*LANE +: LANE];
    return r;
  endfunction
endpackage

// File: rtl/lp_fifo.sv
module lp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, pop;

  assign push      = in_valid && (level != CW'(DEPTH));
  assign out_valid = (level != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/lp_ser.sv
module lp_ser
  import lp_pkg::*;
#(
  parameter int DIVW = 8,
  parameter int LENW = 8,
  localparam int NCW = $clog2(NPQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] clk_div,
  input  logic [LENW-1:0] blk_len,
  input  logic            ck_en,
  input  logic            q_valid,
  output logic            q_ready,
  input  qw_t             q_data,
  input  logic            ack,
  output logic            lclk,
  output logic [NIB-1:0]  ldat,
  output logic            lend,
  output logic            busy
);
  qw_t             shreg, sum;
  logic [NCW-1:0]  nib_cnt;
  logic [DIVW-1:0] div_cnt;
  logic [LENW-1:0] blk_cnt;
  logic            csum_pend;
  logic            start, tick, last_nib, blk_last;
  logic [DIVW:0]   div_nx;
  logic [LENW:0]   blk_nx;

  assign div_nx   = {1'b0, div_cnt} + 1'b1;
  assign tick     = div_nx >= {1'b0, clk_div};
  assign blk_nx   = {1'b0, blk_cnt} + 1'b1;
  assign blk_last = blk_nx >= {1'b0, blk_len};
  assign last_nib = (nib_cnt == NCW'(NPQ - 1));
  assign start    = !busy && ack && (csum_pend || q_valid);
  assign q_ready  = start && !csum_pend;
  assign ldat     = shreg[NIB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      sum       <= '0;
      nib_cnt   <= '0;
      div_cnt   <= '0;
      blk_cnt   <= '0;
      csum_pend <= 1'b0;
      lclk      <= 1'b0;
      lend      <= 1'b0;
      busy      <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      lclk    <= ~lclk;
      nib_cnt <= '0;
      div_cnt <= '0;
      if (csum_pend) begin
        shreg     <= sum;
        lend      <= 1'b1;
        csum_pend <= 1'b0;
        sum       <= '0;
      end else begin
        shreg <= q_data;
        if (blk_last) begin
          blk_cnt <= '0;
          if (ck_en) begin
            csum_pend <= 1'b1;
            sum       <= lane_add(sum, q_data);
            lend      <= 1'b0;
          end else begin
            sum  <= '0;
            lend <= 1'b1;
          end
        end else begin
          blk_cnt <= blk_cnt + 1'b1;
          sum     <= lane_add(sum, q_data);
          lend    <= 1'b0;
        end
      end
    end else if (busy) begin
      if (tick) begin
        div_cnt <= '0;
        if (last_nib) begin
          busy <= 1'b0;
          lend <= 1'b0;
        end else begin
          nib_cnt <= nib_cnt + 1'b1;
          shreg   <= shreg >> NIB;
          lclk    <= ~lclk;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lp_deser.sv
module lp_deser
  import lp_pkg::*;
#(
  localparam int NCW = $clog2(NPQ)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ck_en,
  input  logic           lclk,
  input  logic [NIB-1:0] ldat,
  input  logic           lend,
  output logic           q_valid,
  output logic [QW:0]    q_data,
  output logic           blk_done,
  output logic           ck_err
);
  qw_t            shreg, shnx, sum;
  logic [NCW-1:0] nib_cnt;
  logic           lclk_q, edge_s, qw_done;

  assign edge_s  = lclk ^ lclk_q;
  assign shnx    = {ldat, shreg[QW-1:NIB]};
  assign qw_done = edge_s && (nib_cnt == NCW'(NPQ - 1));
  assign q_valid = qw_done && !(lend && ck_en);
  assign q_data  = {lend, shnx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lclk_q   <= 1'b0;
      shreg    <= '0;
      sum      <= '0;
      nib_cnt  <= '0;
      blk_done <= 1'b0;
      ck_err   <= 1'b0;
    end else begin
      lclk_q   <= lclk;
      blk_done <= 1'b0;
      ck_err   <= 1'b0;
      if (edge_s) begin
        shreg   <= shnx;
        nib_cnt <= nib_cnt + 1'b1;
      end
      if (qw_done) begin
        if (lend) begin
          blk_done <= 1'b1;
          sum      <= '0;
          if (ck_en) ck_err <= (shnx != sum);
        end else begin
          sum <= lane_add(sum, shnx);
        end
      end
    end
  end
endmodule

// File: rtl/lp_link.sv
module lp_link
  import lp_pkg::*;
#(
  parameter int DIVW     = 8,
  parameter int LENW     = 8,
  parameter int TX_DEPTH = 2,
  parameter int RX_DEPTH = 3,
  parameter int ACK_FREE = 2,
  localparam int TCW     = $clog2(TX_DEPTH + 1),
  localparam int RCW     = $clog2(RX_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [QW-1:0]   s_data,
  input  logic [DIVW-1:0] clk_div,
  input  logic [LENW-1:0] blk_len,
  input  logic            tx_ck_en,
  output logic            lk_clk_o,
  output logic [NIB-1:0]  lk_dat_o,
  output logic            lk_end_o,
  input  logic            lk_ack_i,
  input  logic            lk_clk_i,
  input  logic [NIB-1:0]  lk_dat_i,
  input  logic            lk_end_i,
  output logic            lk_ack_o,
  input  logic            rx_ck_en,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [QW-1:0]   m_data,
  output logic            m_last,
  output logic            rx_blk_done,
  output logic            rx_ck_err
);
  logic [TCW-1:0] txq_lvl;
  logic [RCW-1:0] rxq_lvl;
  logic           txq_valid, txq_pop, tx_busy;
  qw_t            txq_data;
  logic           rx_push, rx_full;
  logic [QW:0]    rx_word, rxq_out;

  assign s_ready  = (txq_lvl != TCW'(TX_DEPTH));
  assign rx_full  = (rxq_lvl == RCW'(RX_DEPTH));
  assign lk_ack_o = (RCW'(RX_DEPTH) - rxq_lvl) >= RCW'(ACK_FREE);
  assign m_data   = rxq_out[QW-1:0];
  assign m_last   = rxq_out[QW];

  lp_fifo #(.W(QW), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_data(s_data),
    .out_valid(txq_valid), .out_ready(txq_pop), .out_data(txq_data),
    .level(txq_lvl)
  );

  lp_ser #(.DIVW(DIVW), .LENW(LENW)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .clk_div(clk_div), .blk_len(blk_len), .ck_en(tx_ck_en),
    .q_valid(txq_valid), .q_ready(txq_pop), .q_data(txq_data),
    .ack(lk_ack_i), .lclk(lk_clk_o), .ldat(lk_dat_o), .lend(lk_end_o),
    .busy(tx_busy)
  );

  lp_deser u_des (
    .clk(clk), .rst_n(rst_n), .ck_en(rx_ck_en),
    .lclk(lk_clk_i), .ldat(lk_dat_i), .lend(lk_end_i),
    .q_valid(rx_push), .q_data(rx_word),
    .blk_done(rx_blk_done), .ck_err(rx_ck_err)
  );

  lp_fifo #(.W(QW + 1), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_data(rx_word),
    .out_valid(m_valid), .out_ready(m_ready), .out_data(rxq_out),
    .level(rxq_lvl)
  );
endmodule

// File: rtl/lp_link_chk.sv
module lp_link_chk
  import lp_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           tx_busy,
  input logic           lk_ack_i,
  input logic           lk_clk_o,
  input logic [NIB-1:0] lk_dat_o,
  input logic           rx_push,
  input logic           rx_full,
  input logic           m_valid,
  input logic           m_ready,
  input logic [QW-1:0]  m_data,
  input logic           m_last
);
  p_start_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(lk_ack_i));

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !lk_clk_o);

  p_data_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy) && (lk_dat_o != $past(lk_dat_o)))
      |-> (lk_clk_o != $past(lk_clk_o)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
endmodule

bind lp_link lp_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .lk_ack_i(lk_ack_i),
  .lk_clk_o(lk_clk_o), .lk_dat_o(lk_dat_o), .rx_push(rx_push),
  .rx_full(rx_full), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last)
);

// File: tb/sim_lp_link.sv
`timescale 1ns/1ps
module sim_lp_link;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [127:0] s_data = '0;
  logic [7:0]   clk_div = 8'd1;
  logic [7:0]   blk_len = 8'd1;
  logic         tx_ck_en = 1'b0;
  logic         rx_ck_en = 1'b0;
  logic         lk_clk_o, lk_end_o, lk_ack_o;
  logic [3:0]   lk_dat_o;
  logic         ack_gate = 1'b1;
  logic         m_valid, m_last, rx_blk_done, rx_ck_err;
  logic         m_ready = 1'b1;
  logic [127:0] m_data;

  int n_run = 0, n_fail = 0;
  int got_n = 0, n_done = 0, n_err = 0;
  logic [127:0] got_d [64];
  logic         got_l [64];
  int ncap = 0, cyc = 0, tlast = 0, gap2 = 0;
  logic [127:0] cap = '0;
  logic pclk = 1'b0;

  always #2 clk = ~clk;

  lp_link u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .clk_div(clk_div), .blk_len(blk_len), .tx_ck_en(tx_ck_en),
    .lk_clk_o(lk_clk_o), .lk_dat_o(lk_dat_o), .lk_end_o(lk_end_o),
    .lk_ack_i(lk_ack_o & ack_gate),
    .lk_clk_i(lk_clk_o), .lk_dat_i(lk_dat_o), .lk_end_i(lk_end_o),
    .lk_ack_o(lk_ack_o), .rx_ck_en(rx_ck_en),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .rx_blk_done(rx_blk_done), .rx_ck_err(rx_ck_err)
  );

  // {clk_div, quad-word}
  localparam logic [135:0] VEC [6] = '{
    {8'd1, 128'h0123456789abcdeffedcba9876543210},
    {8'd2, 128'hffffffffffffffffffffffffffffffff},
    {8'd3, 128'h00000000000000000000000000000001},
    {8'd0, 128'h80000000000000000000000000000000},
    {8'd5, 128'hdeadbeefcafef00d0badc0de5a5aa5a5},
    {8'd1, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0}
  };

  always @(negedge clk) begin
    cyc++;
    if (m_valid && m_ready && got_n < 64) begin
      got_d[got_n] = m_data;
      got_l[got_n] = m_last;
      got_n++;
    end
    if (rx_blk_done) n_done++;
    if (rx_ck_err) n_err++;
    if (lk_clk_o != pclk) begin
      if (ncap == 1) gap2 = cyc - tlast;
      tlast = cyc;
      ncap++;
      cap = {lk_dat_o, cap[127:4]};
      pclk = lk_clk_o;
    end
  end

  function automatic logic [127:0] bsum(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = a[8*k +: 8] + b[8*k +: 8];
    return r;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] q);
    s_valid = 1'b1;
    s_data  = q;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1;
    s_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    int k = 0;
    while (got_n < n && k < 4000) begin
      @(negedge clk);
      k++;
    end
    tick;
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  localparam logic [127:0] QA = 128'h11112222333344445555666677778888;
  localparam logic [127:0] QB = 128'h99990000aaaabbbbccccddddeeeeffff;
  localparam logic [127:0] QC = 128'h00ff00ff00ff00ff7f807f807f807f80;
  localparam logic [127:0] QD = 128'hc3c3c3c3a5a5a5a5123456780abcdef0;

  initial begin
    int base, d0, e0, expgap;
    logic [127:0] qd;
    repeat (4) tick;
    rst_n = 1'b1;
    tick;
    // reset state
    chk(s_ready == 1'b1, "R1 ready after reset", 128'(s_ready), 128'd1);
    chk(m_valid == 1'b0, "R6 no output after reset", 128'(m_valid), 128'd0);
    chk(lk_clk_o == 1'b0 && lk_end_o == 1'b0, "R4 clock low after reset", 128'({lk_clk_o, lk_end_o}), 128'd0);
    chk(lk_ack_o == 1'b1, "R5 ack high after reset", 128'(lk_ack_o), 128'd1);

    // table of divisors and quad-words, one block each
    for (int i = 0; i < 6; i++) begin
      clk_div = VEC[i][135:128];
      qd      = VEC[i][127:0];
      expgap  = (VEC[i][135:128] == 8'd0) ? 1 : int'(VEC[i][135:128]);
      base = got_n;
      d0 = n_done;
      ncap = 0;
      send(qd);
      wait_rx(base + 1);
      repeat (8) tick;
      chk(got_d[base] == qd, "R6 loopback data", got_d[base], qd);
      chk(got_l[base] == 1'b1 && n_done == d0 + 1, "R7 single-word block end", 128'({got_l[base], 8'(n_done - d0)}), 128'h101);
      chk(cap == qd, "R2 wire nibbles lsb first", cap, qd);
      chk(ncap == 32, "R2 32 clock changes per word", 128'(ncap), 128'd32);
      chk(gap2 == expgap, "R3 half period", 128'(gap2), 128'(expgap));
      chk(lk_clk_o == 1'b0, "R4 clock idles low", 128'(lk_clk_o), 128'd0);
    end

    // acknowledge low before start: nothing moves
    clk_div = 8'd1;
    ack_gate = 1'b0;
    base = got_n;
    ncap = 0;
    send(QC);
    repeat (200) tick;
    chk(ncap == 0 && got_n == base, "R4 no start while ack low", 128'({8'(ncap), 8'(got_n - base)}), 128'd0);
    ack_gate = 1'b1;
    wait_rx(base + 1);
    chk(got_d[base] == QC, "R4 word sent after ack", got_d[base], QC);

    // acknowledge drops mid-word: that word completes, next waits
    clk_div = 8'd4;
    base = got_n;
    ncap = 0;
    send(QA);
    send(QB);
    while (ncap < 5) @(negedge clk);
    tick;
    ack_gate = 1'b0;
    repeat (400) tick;
    chk(got_n == base + 1 && ncap == 32, "R4 word under way completes", 128'({8'(got_n - base), 8'(ncap)}), 128'h0120);
    ack_gate = 1'b1;
    wait_rx(base + 2);
    chk(got_d[base] == QA && got_d[base+1] == QB, "R1 order kept", got_d[base+1], QB);

    // back-pressure at the output
    clk_div = 8'd1;
    m_ready = 1'b0;
    base = got_n;
    send(QA);
    send(QB);
    send(QC);
    send(QD);
    repeat (300) tick;
    chk(m_valid == 1'b1 && got_n == base, "R6 held under back-pressure", 128'({m_valid, 8'(got_n - base)}), 128'h100);
    chk(lk_ack_o == 1'b0, "R5 ack low with two used", 128'(lk_ack_o), 128'd0);
    chk(s_ready == 1'b0, "R1 transmit buffer full", 128'(s_ready), 128'd0);
    chk(m_data == QA, "R6 head word held", m_data, QA);
    m_ready = 1'b1;
    @(posedge clk);
    #1;
    m_ready = 1'b0;
    @(negedge clk);
    chk(lk_ack_o == 1'b1, "R5 ack high with two free", 128'(lk_ack_o), 128'd1);
    tick;
    m_ready = 1'b1;
    wait_rx(base + 4);
    chk(got_d[base] == QA && got_d[base+1] == QB && got_d[base+2] == QC && got_d[base+3] == QD,
        "R6 order after back-pressure", got_d[base+3], QD);

    // two-word block, no checksum
    blk_len = 8'd2;
    base = got_n;
    d0 = n_done;
    send(QA);
    send(QB);
    wait_rx(base + 2);
    repeat (4) tick;
    chk(got_l[base] == 1'b0 && got_l[base+1] == 1'b1, "R7 last flag on final word", 128'({got_l[base], got_l[base+1]}), 128'b01);
    chk(n_done == d0 + 1, "R7 one block-done pulse", 128'(n_done - d0), 128'd1);

    // checksum on both sides, three-word block
    blk_len = 8'd3;
    tx_ck_en = 1'b1;
    rx_ck_en = 1'b1;
    base = got_n;
    d0 = n_done;
    e0 = n_err;
    send(QA);
    send(QB);
    send(QC);
    wait_rx(base + 3);
    repeat (60) tick;
    chk(got_n == base + 3 && got_d[base+2] == QC && !got_l[base+2], "R8 data words delivered", got_d[base+2], QC);
    chk(cap == bsum(bsum(QA, QB), QC), "R8 trailing lane sum on wire", cap, bsum(bsum(QA, QB), QC));
    chk(n_done == d0 + 1 && n_err == e0, "R9 checksum matches", 128'({8'(n_done - d0), 8'(n_err - e0)}), 128'h0100);

    // receive check only: trailing word equal to the sum
    tx_ck_en = 1'b0;
    blk_len = 8'd2;
    base = got_n;
    d0 = n_done;
    e0 = n_err;
    send(QD);
    send(QD);
    wait_rx(base + 1);
    repeat (60) tick;
    chk(got_n == base + 1, "R9 checksum word not delivered", 128'(got_n - base), 128'd1);
    chk(n_done == d0 + 1 && n_err == e0, "R9 equal sum gives no error", 128'({8'(n_done - d0), 8'(n_err - e0)}), 128'h0100);

    // receive check only: trailing word differs
    e0 = n_err;
    send(QD);
    send(QA);
    repeat (120) tick;
    chk(n_err == e0 + 1, "R9 mismatch flagged", 128'(n_err - e0), 128'd1);

    rx_ck_en = 1'b0;
    blk_len = 8'd1;
    tick;
    finish_up();
  end
endmodule